// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an up-counting timer with a programmable period. It is paced by an instruction-rate enable, and that enable first passes through a selectable input prescaler. On every clock the count is compared with a period register. When a prescaled tick arrives while the two are equal, the count goes back to zero, a one-cycle match strobe is emitted, and an output postscaler advances by one. The postscaler counts match events. Once it has counted the programmed number of them, it raises a sticky interrupt flag, and software clears that flag with a separate clear strobe.

A small register port gives read and write access to three registers: the count, the period and a control register. The control register holds the prescale select, the enable and the postscale select. A write to the count or to the control register restarts both divider stages. A control write leaves the count unchanged. The match strobe is also brought out so that a serial peripheral can use it as a shift-clock source.

Top module: `period_timer`

## Requirements
- R1: After reset the count reads 0x00, the period reads 0xFF, the control register reads 0x00, and the interrupt flag and the match strobe are low.
- R2: Control bits [1:0] select the prescale ratio: 00 gives one count tick per enabled cycle, 01 gives one per 4 and 1x gives one per 16.
- R3: Control bit 2 enables the timer. While it is 0 the count, the prescaler and the postscaler hold their values.
- R4: A count tick that finds the count equal to the period loads 0x00 into the count and drives the match strobe high for exactly the following cycle. Every other count tick adds one to the count. With a period of 0x00, every count tick is a match.
- R5: Control bits [6:3] hold a value N. The interrupt flag sets on every (N+1)-th match, counted from the last restart of the postscaler.
- R6: The interrupt flag stays set until a cycle with the clear input high. If a set and a clear fall in the same cycle, the set wins.
- R7: A write to the count register loads the written value and restarts the prescaler and the postscaler. No count tick happens in that cycle.
- R8: A write to the control register restarts the prescaler and the postscaler and leaves the count unchanged. Control bit 7 always reads 0.
- R9: The read data is selected by address with no wait cycle: address 0 returns the count, 1 the period, 2 the control register and 3 returns zero. Writes use the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Instruction-rate enable that feeds the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | W | Write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| rdata | output | W | Read data for the selected register |
| irq_flag | output | 1 | Sticky interrupt flag |
| match_pulse | output | 1 | One-cycle match strobe |

## Verification
An error in the count shows on the read port in the same cycle, because the read path is combinational. A wrong prescaler phase or compare result shows as a match strobe that arrives one or more enabled cycles too early or too late. An off-by-one in the postscaler is hidden until the next terminal match, where the flag rises one match period away from its expected time. The bench therefore steps a cycle-level model of the requirements and compares all three outputs every cycle under random writes and enables.

// File: rtl/period_timer.sv
module period_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         irq_clr,
  output logic [W-1:0] rdata,
  output logic         irq_flag,
  output logic         match_pulse
);
  localparam int DW = 4;
  localparam logic [W-1:0] PER_RST = {W{1'b1}};

  logic [W-1:0]  cnt, per;
  logic [6:0]    ctl;
  logic [DW-1:0] pre, post, pre_term;

  wire on       = ctl[2];
  wire wr_cnt   = wr_en && addr == 2'd0;
  wire wr_per   = wr_en && addr == 2'd1;
  wire wr_ctl   = wr_en && addr == 2'd2;
  wire restart  = wr_cnt || wr_ctl;
  wire run      = tick_en && on && !restart;

  assign pre_term = ctl[1] ? 4'd15 : (ctl[0] ? 4'd3 : 4'd0);

  wire step     = run && pre == pre_term;
  wire hit      = step && cnt == per;
  wire post_end = post == ctl[6:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      per         <= PER_RST;
      ctl         <= '0;
      pre         <= '0;
      post        <= '0;
      irq_flag    <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      match_pulse <= hit;
      if (wr_cnt)    cnt <= wdata;
      else if (step) cnt <= hit ? '0 : cnt + 1'b1;
      if (wr_per) per <= wdata;
      if (wr_ctl) ctl <= wdata[6:0];
      if (restart) begin
        pre  <= '0;
        post <= '0;
      end else begin
        if (run) pre <= (pre == pre_term) ? '0 : pre + 1'b1;
        if (hit) post <= post_end ? '0 : post + 1'b1;
      end
      if (hit && post_end) irq_flag <= 1'b1;
      else if (irq_clr)    irq_flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = cnt;
      2'd1:    rdata = per;
      2'd2:    rdata = W'({1'b0, ctl});
      default: rdata = '0;
    endcase
  end

  p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!on && !wr_en) |=> $stable(cnt));

  p_match_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && !$past(wr_en)) |-> cnt == '0);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  p_ctl_write_keeps_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> cnt == $past(cnt));

  p_bit7_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd2 |-> rdata[7] == 1'b0);

  p_match_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_pulse) |-> $past(tick_en));
endmodule

// File: tb/sim_period_timer.sv
module sim_period_timer;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, tick_en = 0, wr_en = 0, irq_clr = 0;
  logic [1:0] addr = 0;
  logic [W-1:0] wdata = 0;
  logic [W-1:0] rdata;
  logic irq_flag, match_pulse;
  int errors = 0, checks = 0;
  bit cmp_on = 0, done = 0;

  period_timer #(.W(W)) u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .irq_clr(irq_clr), .rdata(rdata),
    .irq_flag(irq_flag), .match_pulse(match_pulse));

  always #2 clk = ~clk;

  logic [7:0] m_cnt, m_per, m_ctl, m_oldper;
  logic [3:0] m_pre, m_post, m_term;
  logic m_flag, m_match, m_nflag, m_nm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 8'hFF; m_ctl = 0; m_pre = 0; m_post = 0; m_flag = 0; m_match = 0;
    end else begin
      m_term = m_ctl[1] ? 4'd15 : (m_ctl[0] ? 4'd3 : 4'd0);
      m_nm = 0; m_nflag = m_flag; m_oldper = m_per;
      if (irq_clr) m_nflag = 0;
      if (wr_en && addr == 0) begin m_cnt = wdata; m_pre = 0; m_post = 0; end
      else if (wr_en && addr == 2) begin m_ctl = wdata & 8'h7F; m_pre = 0; m_post = 0; end
      else begin
        if (wr_en && addr == 1) m_per = wdata;
        if (tick_en && m_ctl[2]) begin
          if (m_pre == m_term) begin
            m_pre = 0;
            if (m_cnt == m_oldper) begin
              m_cnt = 0; m_nm = 1;
              if (m_post == m_ctl[6:3]) begin m_post = 0; m_nflag = 1; end
              else m_post = m_post + 1;
            end else m_cnt = m_cnt + 1;
          end else m_pre = m_pre + 1;
        end
      end
      m_match = m_nm; m_flag = m_nflag;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_per;
      2'd2: return m_ctl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    if (cmp_on) begin
      #1;
      chk("R9 read", rdata, exp_rd(addr));
      chk("R5 flag", irq_flag, m_flag);
      chk("R4 match", match_pulse, m_match);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d; cyc(); wr_en = 0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1;
    for (int i = 0; i < n; i++) cyc();
    tick_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    #700000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd17));
    @(negedge clk); @(negedge clk);
    rst_n = 1; @(negedge clk);
    rd(0, v); chk("R1 count reset", v, 8'h00);
    rd(1, v); chk("R1 period reset", v, 8'hFF);
    rd(2, v); chk("R1 control reset", v, 8'h00);
    rd(3, v); chk("R9 unused address", v, 8'h00);
    chk("R1 flag reset", irq_flag, 0);
    chk("R1 match reset", match_pulse, 0);

    wr(1, 8'h00); wr(2, 8'h04);
    tick_en = 1;
    for (int i = 0; i < 3; i++) begin
      cyc(); chk("R4 period zero matches every tick", match_pulse, 1);
    end
    tick_en = 0; cyc();
    chk("R4 strobe is one cycle", match_pulse, 0);
    chk("R5 ratio 1 flag", irq_flag, 1);
    irq_clr = 1; cyc(); irq_clr = 0;
    chk("R6 clear", irq_flag, 0);

    wr(1, 8'hFF); wr(2, 8'h05); wr(0, 8'h00);
    ticks(8); rd(0, v); chk("R2 prescale 1:4", v, 8'h02);
    wr(2, 8'h06); ticks(16); rd(0, v); chk("R2 prescale 1:16", v, 8'h03);
    wr(2, 8'h00); rd(0, v); chk("R8 control write keeps count", v, 8'h03);
    ticks(5); rd(0, v); chk("R3 disabled holds", v, 8'h03);
    wr(2, 8'hFF); rd(2, v); chk("R8 bit 7 reads zero", v, 8'h7F);

    wr(1, 8'h01); wr(2, 8'h14); wr(0, 8'h00);
    ticks(5); chk("R5 no flag before third match", irq_flag, 0);
    ticks(1); chk("R5 flag on third match", irq_flag, 1);
    irq_clr = 1; tick_en = 1; wr(0, 8'h01); tick_en = 0; irq_clr = 0;
    chk("R6 clear with restart", irq_flag, 0);
    rd(0, v); chk("R7 count write loads", v, 8'h01);
    ticks(3); wr(0, 8'h00); ticks(4);
    chk("R7 write restarts postscaler", irq_flag, 0);
    ticks(2); chk("R7 flag after restart count", irq_flag, 1);
    irq_clr = 1; cyc(); irq_clr = 0;

    cmp_on = 1;
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      tick_en = $urandom_range(0, 1);
      irq_clr = ($urandom_range(0, 19) == 0);
      wr_en = 0;
      addr = 2'($urandom_range(0, 3));
      if (r < 3) begin wr_en = 1; addr = 0; wdata = 8'($urandom_range(0, 7)); end
      else if (r < 6) begin wr_en = 1; addr = 1; wdata = 8'($urandom_range(0, 9)); end
      else if (r < 8) begin
        wr_en = 1; addr = 2;
        wdata = {1'($urandom_range(0,1)), 4'($urandom_range(0,3)),
                 1'($urandom_range(0,4) != 0), 2'($urandom_range(0,3))};
      end
      cyc();
    end
    wr_en = 0; tick_en = 0; irq_clr = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule